// File: doc/BRIEF.md
# Synchronous Clock Domain Enable Generator

This block produces the clock enables for four related synchronous domains: CPU, high-speed bus (HSB), peripheral bus A (PBA) and peripheral bus B (PBB). Everything runs on one fast system clock, and all clocking is expressed as one-cycle enables. Two source tick inputs, `osc_tick` and `pll_tick`, mark the edges of the oscillator and the PLL. A selected source bit picks one of them as the main tick.

The main tick advances one shared 8-bit prescaler. Each domain either follows the main tick directly or takes one prescaler tap. Tap n pulses once every 2^(n+1) main ticks. Each domain fans its enable out to a row of per-module enables, and each row has its own mask register. A per-domain sleep input silences a whole domain while it is high.

A new configuration is offered on a valid/ready port. The configuration holds the source bit, the four divide-enable bits and the four tap fields. A transfer happens on any cycle where `cfg_valid` and `cfg_ready` are both high. The producer may drop or change the offer at any time; nothing is taken while `cfg_ready` is low. An accepted configuration waits until every divided domain lines up, so no domain ever sees a shortened period. An offer that breaks the frequency ordering is discarded and flagged.

Top module: `sclk_gen`

## Requirements
- R1: After reset, the oscillator tick is the source and all four domains are undivided. Every mask bit is 1, `cfg_err` is 0 and `cfg_ready` is 1.
- R2: The main tick is `pll_tick` when the applied source bit is 1, and `osc_tick` when it is 0. No domain enable is ever high on a cycle in which the main tick is low.
- R3: The prescaler count advances by one on each main tick, wraps from 255 to 0, and holds on every other cycle.
- R4: Domains sit at indices 0 = CPU, 1 = HSB, 2 = PBA, 3 = PBB. A domain with divide-enable 0 pulses `dom_en` on every main tick. A domain with divide-enable 1 and tap n (field bits [3d+2:3d] of `cfg_tap`) pulses only on main ticks where count+1 is a multiple of 2^(n+1). The enable is combinational in the tick's own cycle.
- R5: Each domain has an exponent e, equal to n+1 when it is divided and 0 when it is not. An offer is accepted only if e_CPU ≤ e_HSB, e_PBB = e_HSB and e_HSB ≤ e_PBA.
- R6: A rejected offer leaves the applied settings unchanged and raises `cfg_err` on the next cycle. An accepted offer clears `cfg_err` on the next cycle.
- R7: An accepted offer drops `cfg_ready` from the next cycle onward. Consider the first later cycle where the main tick is high and the count is 255. The offer takes effect in the cycle after that one, and `cfg_ready` returns high in the same cycle.
- R8: While `sleep[d]` is high, `dom_en[d]` and that domain's module enables are low in the same cycle. The prescaler keeps counting.
- R9: `mod_en[d*NMOD+m]` equals `dom_en[d]` AND mask bit m of domain d. A pulse on `mask_we[d]` loads `mask_wdata` into that domain's mask from the next cycle on.
- R10: Offers made while `cfg_ready` is low have no effect on the applied settings, on the pending offer, or on `cfg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | Oscillator edge marker |
| pll_tick | input | 1 | PLL edge marker |
| cfg_valid | input | 1 | Configuration offer valid |
| cfg_ready | output | 1 | Configuration port free |
| cfg_pll | input | 1 | Source bit: 1 selects PLL |
| cfg_div_en | input | 4 | Per-domain divide enable |
| cfg_tap | input | 12 | Per-domain tap select, 3 bits each |
| cfg_err | output | 1 | Last accepted-or-rejected offer was rejected |
| mask_we | input | 4 | Per-domain mask write strobe |
| mask_wdata | input | NMOD | Mask value to write |
| sleep | input | 4 | Per-domain sleep request |
| dom_en | output | 4 | Domain enables |
| mod_en | output | 4*NMOD | Per-module enables, domain-major |

## Verification
The outputs fall due at different cycles:

- Domain and module enables are combinational. They are due in the same cycle as the tick that causes them.
- `cfg_err` and the drop of `cfg_ready` are due one edge after the handshake.
- Mask writes act from the cycle after the strobe.
- New divider settings act from the cycle after the wrap tick.

The bench keeps a cycle-accurate arithmetic model. Inputs are driven just after a rising edge, all outputs are compared one nanosecond after the falling edge, and the model state advances only at the rising edge. Every comparison is therefore made against the state that edge produced.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int NDOM    = 4;
  localparam int DOM_CPU = 0;
  localparam int DOM_HSB = 1;
  localparam int DOM_PBA = 2;
  localparam int DOM_PBB = 3;
endpackage

// File: rtl/sclk_prescaler.sv
module sclk_prescaler #(
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  output logic [PW-1:0] cnt,
  output logic [PW-1:0] tap_pulse,
  output logic          wrap
);
  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end

  // Tap n fires when the low n+1 count bits are all ones.
  for (genvar n = 0; n < PW; n++) begin : g_tap
    assign tap_pulse[n] = tick && (&cnt[n:0]);
  end

  assign wrap = tap_pulse[PW-1];
endmodule

// File: rtl/sclk_cfg_ctrl.sv
module sclk_cfg_ctrl
  import sclk_pkg::*;
#(
  parameter int PW = 8,
  parameter int TW = $clog2(PW)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  output logic               cfg_ready,
  input  logic               cfg_pll,
  input  logic [NDOM-1:0]    cfg_div_en,
  input  logic [NDOM*TW-1:0] cfg_tap,
  output logic               cfg_err,
  input  logic               wrap,
  output logic               act_pll,
  output logic [NDOM-1:0]    act_div_en,
  output logic [NDOM*TW-1:0] act_tap
);
  logic               pend;
  logic               pnd_pll;
  logic [NDOM-1:0]    pnd_div_en;
  logic [NDOM*TW-1:0] pnd_tap;
  logic [TW:0]        ex [NDOM];
  logic               taps_ok;
  logic               order_ok;
  logic               hs;

  always_comb begin
    taps_ok = 1'b1;
    for (int d = 0; d < NDOM; d++) begin
      ex[d] = cfg_div_en[d] ? ({1'b0, cfg_tap[d*TW +: TW]} + 1'b1) : '0;
      if (cfg_div_en[d] && (int'(cfg_tap[d*TW +: TW]) >= PW)) taps_ok = 1'b0;
    end
    order_ok = (ex[DOM_CPU] <= ex[DOM_HSB]) && (ex[DOM_PBB] == ex[DOM_HSB]) &&
               (ex[DOM_HSB] <= ex[DOM_PBA]);
  end

  assign cfg_ready = !pend;
  assign hs        = cfg_valid && cfg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend       <= 1'b0;
      cfg_err    <= 1'b0;
      pnd_pll    <= 1'b0;
      pnd_div_en <= '0;
      pnd_tap    <= '0;
      act_pll    <= 1'b0;
      act_div_en <= '0;
      act_tap    <= '0;
    end else if (hs) begin
      if (taps_ok && order_ok) begin
        pend       <= 1'b1;
        cfg_err    <= 1'b0;
        pnd_pll    <= cfg_pll;
        pnd_div_en <= cfg_div_en;
        pnd_tap    <= cfg_tap;
      end else begin
        cfg_err <= 1'b1;
      end
    end else if (pend && wrap) begin
      pend       <= 1'b0;
      act_pll    <= pnd_pll;
      act_div_en <= pnd_div_en;
      act_tap    <= pnd_tap;
    end
  end
endmodule

// File: rtl/sclk_domain.sv
module sclk_domain #(
  parameter int PW   = 8,
  parameter int TW   = $clog2(PW),
  parameter int NMOD = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            main_tick,
  input  logic [PW-1:0]   tap_pulse,
  input  logic            div_en,
  input  logic [TW-1:0]   tap,
  input  logic            sleep,
  input  logic            mask_we,
  input  logic [NMOD-1:0] mask_wdata,
  output logic            dom_en,
  output logic [NMOD-1:0] mod_en
);
  logic [NMOD-1:0] mask;
  logic            raw;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask <= '1;
    else if (mask_we) mask <= mask_wdata;
  end

  assign raw    = div_en ? tap_pulse[tap] : main_tick;
  assign dom_en = raw && !sleep;
  assign mod_en = {NMOD{dom_en}} & mask;
endmodule

// File: rtl/sclk_gen.sv
module sclk_gen
  import sclk_pkg::*;
#(
  parameter int PW   = 8,
  parameter int NMOD = 4,
  localparam int TW  = $clog2(PW)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 osc_tick,
  input  logic                 pll_tick,
  input  logic                 cfg_valid,
  output logic                 cfg_ready,
  input  logic                 cfg_pll,
  input  logic [NDOM-1:0]      cfg_div_en,
  input  logic [NDOM*TW-1:0]   cfg_tap,
  output logic                 cfg_err,
  input  logic [NDOM-1:0]      mask_we,
  input  logic [NMOD-1:0]      mask_wdata,
  input  logic [NDOM-1:0]      sleep,
  output logic [NDOM-1:0]      dom_en,
  output logic [NDOM*NMOD-1:0] mod_en
);
  logic               act_pll;
  logic [NDOM-1:0]    act_div_en;
  logic [NDOM*TW-1:0] act_tap;
  logic               main_tick;
  logic [PW-1:0]      psc_cnt;
  logic [PW-1:0]      tap_pulse;
  logic               psc_wrap;

  assign main_tick = act_pll ? pll_tick : osc_tick;

  sclk_prescaler #(.PW(PW)) u_psc (
    .clk(clk), .rst_n(rst_n), .tick(main_tick),
    .cnt(psc_cnt), .tap_pulse(tap_pulse), .wrap(psc_wrap)
  );

  sclk_cfg_ctrl #(.PW(PW), .TW(TW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_pll(cfg_pll), .cfg_div_en(cfg_div_en), .cfg_tap(cfg_tap),
    .cfg_err(cfg_err), .wrap(psc_wrap), .act_pll(act_pll),
    .act_div_en(act_div_en), .act_tap(act_tap)
  );

  for (genvar d = 0; d < NDOM; d++) begin : g_dom
    sclk_domain #(.PW(PW), .TW(TW), .NMOD(NMOD)) u_dom (
      .clk(clk), .rst_n(rst_n), .main_tick(main_tick), .tap_pulse(tap_pulse),
      .div_en(act_div_en[d]), .tap(act_tap[d*TW +: TW]), .sleep(sleep[d]),
      .mask_we(mask_we[d]), .mask_wdata(mask_wdata),
      .dom_en(dom_en[d]), .mod_en(mod_en[d*NMOD +: NMOD])
    );
  end
endmodule

// File: rtl/sclk_checker.sv
module sclk_checker
  import sclk_pkg::*;
#(
  parameter int PW   = 8,
  parameter int NMOD = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 osc_tick,
  input logic                 pll_tick,
  input logic                 cfg_valid,
  input logic                 cfg_ready,
  input logic                 cfg_err,
  input logic [NDOM-1:0]      sleep,
  input logic [NDOM-1:0]      dom_en,
  input logic [NDOM*NMOD-1:0] mod_en,
  input logic [PW-1:0]        cnt,
  input logic                 tick,
  input logic                 wrap
);
  logic [NDOM*NMOD-1:0] dom_rep;
  for (genvar d = 0; d < NDOM; d++) begin : g_rep
    assign dom_rep[d*NMOD +: NMOD] = {NMOD{dom_en[d]}};
  end

  p_tick_src_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|dom_en) |-> (osc_tick || pll_tick));

  p_cnt_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> (cnt == PW'($past(cnt) + 1'b1)));

  p_cnt_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt));

  p_err_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_err) |-> $past(cfg_valid && cfg_ready));

  p_ready_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_ready) |-> $past(wrap));

  p_sleep_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dom_en & sleep) == '0);

  p_mask_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mod_en & ~dom_rep) == '0);
endmodule

bind sclk_gen sclk_checker #(.PW(PW), .NMOD(NMOD)) u_chk (
  .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .pll_tick(pll_tick),
  .cfg_valid(cfg_valid), .cfg_ready(cfg_ready), .cfg_err(cfg_err),
  .sleep(sleep), .dom_en(dom_en), .mod_en(mod_en),
  .cnt(psc_cnt), .tick(main_tick), .wrap(psc_wrap)
);

// File: tb/tb_sclk_gen.sv
`timescale 1ns/1ps
module tb_sclk_gen;
  localparam int PW = 8, NMOD = 4, TW = 3, ND = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic osc_tick = 1'b0, pll_tick = 1'b0, cfg_valid = 1'b0, cfg_pll = 1'b0;
  logic [ND-1:0] cfg_div_en = '0, mask_we = '0, sleep = '0;
  logic [ND*TW-1:0] cfg_tap = '0;
  logic [NMOD-1:0] mask_wdata = '0;
  logic cfg_ready, cfg_err;
  logic [ND-1:0] dom_en;
  logic [ND*NMOD-1:0] mod_en;

  sclk_gen #(.PW(PW), .NMOD(NMOD)) dut (.*);

  always #2.5 clk = ~clk;

  int vecs = 0, errs = 0;
  int m_cnt = 0;
  bit m_pll = 0, m_pend = 0, m_err = 0, p_pll = 0;
  int m_e[ND], p_e[ND];
  logic [NMOD-1:0] m_mask[ND];
  logic [15:0] lf = 16'hACE1;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int e_in(int d);
    return cfg_div_en[d] ? int'(cfg_tap[d*TW +: TW]) + 1 : 0;
  endfunction

  function automatic bit cur_tick();
    return m_pll ? pll_tick : osc_tick;
  endfunction

  task automatic step();
    logic [ND-1:0] ed;
    logic [ND*NMOD-1:0] em;
    bit t, hs, wrap;
    @(negedge clk); #1;
    t = cur_tick();
    for (int d = 0; d < ND; d++) begin
      if (m_e[d] == 0) ed[d] = t;
      else ed[d] = t && (((m_cnt + 1) % (1 << m_e[d])) == 0);
      ed[d] = ed[d] && !sleep[d];
      em[d*NMOD +: NMOD] = {NMOD{ed[d]}} & m_mask[d];
    end
    chk("R4 dom_en", 64'(dom_en), 64'(ed));
    chk("R9 mod_en", 64'(mod_en), 64'(em));
    chk("R7 cfg_ready", 64'(cfg_ready), 64'(!m_pend));
    chk("R6 cfg_err", 64'(cfg_err), 64'(m_err));
    @(posedge clk);
    hs = cfg_valid && !m_pend;
    wrap = t && (m_cnt == 255);
    if (hs) begin
      if (e_in(0) <= e_in(1) && e_in(3) == e_in(1) && e_in(1) <= e_in(2)) begin
        m_pend = 1; m_err = 0; p_pll = cfg_pll;
        for (int d = 0; d < ND; d++) p_e[d] = e_in(d);
      end else m_err = 1;
    end else if (wrap && m_pend) begin
      m_pend = 0; m_pll = p_pll;
      for (int d = 0; d < ND; d++) m_e[d] = p_e[d];
    end
    for (int d = 0; d < ND; d++) if (mask_we[d]) m_mask[d] = mask_wdata;
    if (t) m_cnt = (m_cnt + 1) % 256;
    #1;
  endtask

  task automatic run(int n, int mode);
    for (int i = 0; i < n; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      osc_tick = (mode == 0) ? 1'b1 : lf[0];
      pll_tick = (i % 3) == 0;
      step();
    end
  endtask

  task automatic set_cfg(bit pll, int ec, int eh, int ea, int eb);
    int ee[ND];
    ee[0] = ec; ee[1] = eh; ee[2] = ea; ee[3] = eb;
    cfg_pll = pll;
    for (int d = 0; d < ND; d++) begin
      cfg_div_en[d] = ee[d] > 0;
      cfg_tap[d*TW +: TW] = (ee[d] > 0) ? 3'(ee[d] - 1) : 3'd0;
    end
  endtask

  task automatic send(bit pll, int ec, int eh, int ea, int eb);
    while (m_pend) run(1, 0);
    set_cfg(pll, ec, eh, ea, eb);
    cfg_valid = 1'b1; step(); cfg_valid = 1'b0;
  endtask

  initial begin
    #1000000;
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    for (int d = 0; d < ND; d++) begin m_e[d] = 0; p_e[d] = 0; m_mask[d] = '1; end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: reset state, undivided oscillator source
    osc_tick = 1'b1;
    @(negedge clk); #1;
    chk("R1 dom_en", 64'(dom_en), 64'hF);
    chk("R1 mod_en", 64'(mod_en), 64'hFFFF);
    chk("R1 ready/err", 64'({cfg_ready, cfg_err}), 64'b10);
    @(posedge clk); m_cnt = 1; #1;
    // R2 R3: undivided with irregular oscillator ticks
    run(300, 1);
    // R4 R5 R7: sweep every legal exponent pairing
    for (int eh = 0; eh <= 8; eh++)
      for (int ea = eh; ea <= 8; ea++) begin
        send(0, eh / 2, eh, ea, eh);
        run(300, (eh + ea) % 2);
      end
    // R5 R6: illegal orderings rejected, settings kept
    send(0, 3, 2, 2, 2); run(20, 0);
    send(0, 1, 2, 1, 2); run(20, 0);
    send(0, 1, 2, 3, 3); run(20, 0);
    send(0, 0, 1, 1, 1); run(300, 0);
    // R10: offers while pending are ignored
    send(0, 1, 2, 4, 2);
    set_cfg(0, 5, 1, 1, 1); cfg_valid = 1'b1;
    while (m_pend) run(1, 0);
    cfg_valid = 1'b0; run(100, 0);
    // R2: switch to PLL source
    send(1, 0, 2, 3, 2); run(1000, 1);
    // R8: sleep patterns
    for (int i = 0; i < 200; i++) begin sleep = lf[7:4]; run(1, 1); end
    sleep = '0;
    // R9: mask writes
    for (int i = 0; i < 64; i++) begin
      mask_we = lf[3:0]; mask_wdata = lf[11:8]; run(1, 0);
    end
    mask_we = '0; run(100, 0);
    send(0, 0, 0, 0, 0); run(300, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule